// File: doc/BRIEF.md
# Four-Channel Bus-Master DMA Controller

This block moves data between peripherals and memory on behalf of a CPU. The CPU first sets it up as a register target. For each of four channels it writes a 16-bit start address and a 14-bit transfer count, and it writes a mode byte that enables channels and picks the priority scheme. Once a peripheral raises its request line, the controller asks the CPU for the bus with a hold request. When the CPU grants the bus, the controller becomes the bus master. It then acknowledges the winning channel, puts the memory address on the bus and pulses the read and write strobes that match the transfer direction.

Each transfer takes two cycles. In the first cycle the upper address byte is placed on the data bus and an address strobe lets an external latch capture it. In the second cycle the memory and I/O strobes are active. The four low address lines double as register-select inputs when the CPU is the bus owner. A terminal-count output marks the last transfer of a block. A mark output pulses after every 128th transfer, counted from the start of the block.

Top module: `dmac4_top`

## Requirements
- R1: Register select works as follows. With `addr_in[3]`=0, `addr_in[2:1]` picks the channel, and `addr_in[0]`=0 selects its address register while `addr_in[0]`=1 selects its count register. Both registers are accessed as two byte transfers, low byte first. A byte toggle flips on every channel-register read or write. The high count byte holds the transfer kind in bits 7:6 and count bits 13:8 in bits 5:0. A read returns the bytes in the same order they were written.
- R2: Writing `addr_in`=8 sets the mode: bits 3:0 enable channels 0..3 and bit 4 selects rotating priority. A mode write also returns the byte toggle to the low byte.
- R3: After reset `hrq`=0, every `dack_n` is high and all strobes are inactive. A request on an enabled channel raises `hrq` one cycle later. No acknowledge or strobe appears until `hlda` is seen high.
- R4: In fixed priority, the lowest-numbered requesting enabled channel is granted, and only one `dack_n` is ever low.
- R5: In rotating priority, the order starts with channel 0 first. When a channel's service ends, that channel becomes the lowest priority.
- R6: The first cycle of each transfer raises `adstb`, drives address bits 15:8 on `dout` with `dout_en` high, and drives bits 7:4 and 3:0 on `addr_mid_out` and `addr_lo_out`.
- R7: The transfer kind sets the strobes in the second cycle. Kind 2'b10 (read) drives `memr_n` and `iow_n` low. Kind 2'b01 (write) drives `ior_n` and `memw_n` low. Kind 2'b00 (verify) drives no strobe.
- R8: Each transfer increments the channel address and decrements the count. A loaded count C gives C+1 transfers, and an interrupted block resumes from where it stopped.
- R9: `tc` is high together with the acknowledge of the last transfer. The next cycle releases the acknowledge and `hrq`. The channel's enable bit clears and its bit in the status byte (read at `addr_in`=8, bits 3:0) is set. Reading the status byte clears it.
- R10: `mark` is high with the acknowledge of transfer k of a block whenever k is a multiple of 128.
- R11: If the serviced channel's request is low during a transfer cycle, that transfer completes. The acknowledge and `hrq` are released in the next cycle, and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register target select from the CPU |
| cpu_rd | input | 1 | CPU register read strobe, active high |
| cpu_wr | input | 1 | CPU register write strobe, active high |
| addr_in | input | 4 | Register select while the CPU owns the bus |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Register read data, or upper address byte while `adstb` is high |
| dout_en | output | 1 | Data bus drive enable |
| addr_lo_out | output | 4 | Address bits 3:0 while mastering |
| addr_mid_out | output | 4 | Address bits 7:4 while mastering |
| addr_oe | output | 1 | Address outputs valid (bus owned) |
| drq | input | 4 | Per-channel transfer requests |
| dack_n | output | 4 | Per-channel acknowledges, active low |
| hrq | output | 1 | Bus hold request to the CPU |
| hlda | input | 1 | Bus hold granted by the CPU |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | Peripheral read strobe, active low |
| iow_n | output | 1 | Peripheral write strobe, active low |
| adstb | output | 1 | Upper address byte latch strobe |
| tc | output | 1 | Last transfer of a block |
| mark | output | 1 | Every 128th transfer of a block |

## Verification
The bench checks the following corner cases, and what a faulty design would do in each:

- A mode write in the middle of a register pair must reset the byte toggle. If it did not, the bench would read the high and low bytes swapped.
- Holding `hlda` low while requests are pending would expose a design that acknowledges before the bus grant.
- Two channels request at once in both priority modes. A design without rotation would grant channel 0 a second time in a row.
- A 256-transfer block crosses the high-byte boundary and must show marks only at transfers 128 and 256. Counting marks from the end of the block, or off by one, would place them elsewhere.
- A request is dropped in the middle of a block and then raised again. The design must release the bus without setting status, and must resume at the next address instead of restarting or skipping one.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = 16;
    localparam int CW  = 14;
    localparam logic [3:0] MODE_SEL = 4'h8;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'b00,
        XF_WRITE  = 2'b01,
        XF_READ   = 2'b10,
        XF_RSVD   = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_ADDR, ST_XFER} seq_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] base;
        xfer_e         kind;
    } chan_t;

    // internal strobes, active high
    typedef struct packed {
        logic memr;
        logic memw;
        logic ior;
        logic iow;
    } strobe_t;

    function automatic strobe_t kind_strobes(xfer_e k);
        strobe_t s;
        s = '0;
        case (k)
            XF_READ:  begin s.memr = 1'b1; s.iow  = 1'b1; end
            XF_WRITE: begin s.ior  = 1'b1; s.memw = 1'b1; end
            default:  ;
        endcase
        return s;
    endfunction

    // true when the transfer now under way is a multiple of 2**lg from block start
    function automatic logic mark_due(logic [CW-1:0] base, logic [CW-1:0] cur, int unsigned lg);
        logic [CW-1:0] done;
        logic [CW-1:0] mask;
        done = base - cur + CW'(1);
        mask = CW'((1 << lg) - 1);
        return (done & mask) == '0;
    endfunction
endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs import dmac_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs,
    input  logic                  rd_stb,
    input  logic                  wr_stb,
    input  logic [3:0]            reg_sel,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output chan_t [NCH-1:0]       chans,
    output logic [NCH-1:0]        ch_en,
    output logic                  rotate,
    input  logic                  upd_valid,
    input  logic [CHW-1:0]        upd_ch,
    input  logic                  upd_tc
);
    logic           byte_hi;
    logic [NCH-1:0] tc_flag;
    logic           chan_hit;
    logic           mode_hit;
    logic [CHW-1:0] sel_ch;
    logic           sel_cnt;
    logic [NCH-1:0] tc_set;
    logic [NCH-1:0] tc_clr;

    assign chan_hit = cs && !reg_sel[3];
    assign mode_hit = cs && (reg_sel == MODE_SEL);
    assign sel_ch   = reg_sel[CHW:1];
    assign sel_cnt  = reg_sel[0];
    assign tc_set   = (upd_valid && upd_tc) ? (NCH'(1) << upd_ch) : '0;
    assign tc_clr   = (mode_hit && rd_stb) ? '1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            chans   <= '0;
            ch_en   <= '0;
            rotate  <= 1'b0;
            byte_hi <= 1'b0;
            tc_flag <= '0;
        end else begin
            tc_flag <= (tc_flag & ~tc_clr) | tc_set;
            if (mode_hit && wr_stb) begin
                ch_en   <= wdata[NCH-1:0];
                rotate  <= wdata[NCH];
                byte_hi <= 1'b0;
            end else if (chan_hit && (wr_stb || rd_stb)) begin
                byte_hi <= !byte_hi;
            end
            if (chan_hit && wr_stb) begin
                if (!sel_cnt) begin
                    if (byte_hi) chans[sel_ch].addr[AW-1:8] <= wdata;
                    else         chans[sel_ch].addr[7:0]    <= wdata;
                end else if (!byte_hi) begin
                    chans[sel_ch].cnt[7:0]  <= wdata;
                    chans[sel_ch].base[7:0] <= wdata;
                end else begin
                    chans[sel_ch].cnt[CW-1:8]  <= wdata[CW-9:0];
                    chans[sel_ch].base[CW-1:8] <= wdata[CW-9:0];
                    chans[sel_ch].kind         <= xfer_e'(wdata[7:6]);
                end
            end
            if (upd_valid) begin
                chans[upd_ch].addr <= chans[upd_ch].addr + AW'(1);
                chans[upd_ch].cnt  <= chans[upd_ch].cnt - CW'(1);
                if (upd_tc) ch_en[upd_ch] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (mode_hit) begin
            rdata = 8'(tc_flag);
        end else if (chan_hit) begin
            if (!sel_cnt)
                rdata = byte_hi ? chans[sel_ch].addr[AW-1:8] : chans[sel_ch].addr[7:0];
            else
                rdata = byte_hi ? {chans[sel_ch].kind, chans[sel_ch].cnt[CW-1:8]}
                                : chans[sel_ch].cnt[7:0];
        end
    end
endmodule

// File: rtl/dmac_arb.sv
`timescale 1ns/1ps
module dmac_arb import dmac_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  req,
    input  logic            rotate,
    input  logic            served,
    input  logic [CHW-1:0]  served_ch,
    output logic            win_valid,
    output logic [CHW-1:0]  win_ch
);
    logic [CHW-1:0] head;

    always_ff @(posedge clk) begin
        if (rst || !rotate) head <= '0;
        else if (served)    head <= served_ch + CHW'(1);
    end

    // scan from lowest priority to highest so the highest match lands last
    always_comb begin
        win_valid = 1'b0;
        win_ch    = head;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[head + CHW'(i)]) begin
                win_valid = 1'b1;
                win_ch    = head + CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
module dmac_seq import dmac_pkg::*; #(
    parameter int MARK_LOG2 = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  drq,
    input  logic            hlda,
    input  logic            win_valid,
    input  logic [CHW-1:0]  win_ch,
    input  chan_t [NCH-1:0] chans,
    output logic            hrq,
    output logic [NCH-1:0]  dack,
    output strobe_t         stb,
    output logic            adstb,
    output logic            bus_own,
    output logic [AW-1:0]   cur_addr,
    output logic            tc,
    output logic            mark,
    output logic            upd_valid,
    output logic [CHW-1:0]  upd_ch,
    output logic            upd_tc,
    output logic            served
);
    seq_e           st, st_nx;
    logic [CHW-1:0] ch;
    chan_t          cur;
    logic           last;

    assign cur      = chans[ch];
    assign last     = (cur.cnt == '0);
    assign cur_addr = cur.addr;
    assign upd_ch   = ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            ch <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_HOLD && hlda && win_valid) ch <= win_ch;
        end
    end

    always_comb begin
        st_nx     = st;
        hrq       = 1'b0;
        dack      = '0;
        stb       = '0;
        adstb     = 1'b0;
        bus_own   = 1'b0;
        tc        = 1'b0;
        mark      = 1'b0;
        upd_valid = 1'b0;
        upd_tc    = 1'b0;
        served    = 1'b0;
        case (st)
            ST_IDLE: if (win_valid) st_nx = ST_HOLD;
            ST_HOLD: begin
                hrq = 1'b1;
                if (!win_valid) st_nx = ST_IDLE;
                else if (hlda)  st_nx = ST_ADDR;
            end
            ST_ADDR: begin
                hrq      = 1'b1;
                dack[ch] = 1'b1;
                adstb    = 1'b1;
                bus_own  = 1'b1;
                if (!drq[ch]) begin
                    st_nx  = ST_IDLE;
                    served = 1'b1;
                end else begin
                    st_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                hrq       = 1'b1;
                dack[ch]  = 1'b1;
                bus_own   = 1'b1;
                stb       = kind_strobes(cur.kind);
                tc        = last;
                mark      = mark_due(cur.base, cur.cnt, MARK_LOG2);
                upd_valid = 1'b1;
                upd_tc    = last;
                if (last || !drq[ch]) begin
                    st_nx  = ST_IDLE;
                    served = 1'b1;
                end else begin
                    st_nx = ST_ADDR;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dmac4_top.sv
`timescale 1ns/1ps
module dmac4_top import dmac_pkg::*; #(
    parameter int MARK_LOG2 = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    input  logic [3:0]     addr_in,
    input  logic [7:0]     din,
    output logic [7:0]     dout,
    output logic           dout_en,
    output logic [3:0]     addr_lo_out,
    output logic [3:0]     addr_mid_out,
    output logic           addr_oe,
    input  logic [NCH-1:0] drq,
    output logic [NCH-1:0] dack_n,
    output logic           hrq,
    input  logic           hlda,
    output logic           memr_n,
    output logic           memw_n,
    output logic           ior_n,
    output logic           iow_n,
    output logic           adstb,
    output logic           tc,
    output logic           mark
);
    chan_t [NCH-1:0] chans;
    logic [NCH-1:0]  ch_en;
    logic            rotate;
    logic [7:0]      rdata;
    logic            cs_eff;
    logic            win_valid;
    logic [CHW-1:0]  win_ch;
    logic [NCH-1:0]  dack;
    strobe_t         stb;
    logic            bus_own;
    logic [AW-1:0]   cur_addr;
    logic            upd_valid;
    logic [CHW-1:0]  upd_ch;
    logic            upd_tc;
    logic            served;

    assign cs_eff = cs && !bus_own;

    dmac_regs u_regs (
        .clk(clk), .rst(rst), .cs(cs_eff),
        .rd_stb(cpu_rd), .wr_stb(cpu_wr),
        .reg_sel(addr_in), .wdata(din), .rdata(rdata),
        .chans(chans), .ch_en(ch_en), .rotate(rotate),
        .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_tc(upd_tc)
    );

    dmac_arb u_arb (
        .clk(clk), .rst(rst), .req(drq & ch_en), .rotate(rotate),
        .served(served), .served_ch(upd_ch),
        .win_valid(win_valid), .win_ch(win_ch)
    );

    dmac_seq #(.MARK_LOG2(MARK_LOG2)) u_seq (
        .clk(clk), .rst(rst), .drq(drq), .hlda(hlda),
        .win_valid(win_valid), .win_ch(win_ch), .chans(chans),
        .hrq(hrq), .dack(dack), .stb(stb), .adstb(adstb),
        .bus_own(bus_own), .cur_addr(cur_addr), .tc(tc), .mark(mark),
        .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_tc(upd_tc),
        .served(served)
    );

    assign dout         = adstb ? cur_addr[AW-1:8] : (bus_own ? 8'h00 : rdata);
    assign dout_en      = adstb || (cs_eff && cpu_rd);
    assign addr_lo_out  = cur_addr[3:0];
    assign addr_mid_out = cur_addr[7:4];
    assign addr_oe      = bus_own;
    assign dack_n       = ~dack;
    assign memr_n       = !stb.memr;
    assign memw_n       = !stb.memw;
    assign ior_n        = !stb.ior;
    assign iow_n        = !stb.iow;
endmodule

// File: rtl/dmac4_sva.sv
`timescale 1ns/1ps
module dmac4_sva import dmac_pkg::*; (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] drq,
    input logic [NCH-1:0] dack_n,
    input logic           hrq,
    input logic           memr_n,
    input logic           memw_n,
    input logic           ior_n,
    input logic           iow_n,
    input logic           adstb,
    input logic           dout_en,
    input logic           tc,
    input logic           mark
);
    a_r3_ack_needs_hold: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1) |-> hrq);

    a_r3_no_ack_on_hold_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(hrq) |-> (dack_n == '1));

    a_r4_single_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    a_r6_latch_drives_bus: assert property (@(posedge clk) disable iff (rst)
        adstb |-> (dout_en && dack_n != '1));

    a_r7_read_pairing: assert property (@(posedge clk) disable iff (rst)
        !memr_n |-> (!iow_n && memw_n && ior_n));

    a_r7_write_pairing: assert property (@(posedge clk) disable iff (rst)
        !memw_n |-> (!ior_n && memr_n && iow_n));

    a_r9_tc_on_transfer: assert property (@(posedge clk) disable iff (rst)
        tc |-> (dack_n != '1 && !adstb));

    a_r9_release_after_tc: assert property (@(posedge clk) disable iff (rst)
        tc |=> (dack_n == '1 && !hrq));

    a_r10_mark_on_transfer: assert property (@(posedge clk) disable iff (rst)
        mark |-> (dack_n != '1 && !adstb));

    a_r11_release_on_drop: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1 && !adstb && ((drq & ~dack_n) == '0)) |=> (dack_n == '1));
endmodule

bind dmac4_top dmac4_sva u_sva (
    .clk(clk), .rst(rst), .drq(drq), .dack_n(dack_n), .hrq(hrq),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .adstb(adstb), .dout_en(dout_en), .tc(tc), .mark(mark)
);

// File: tb/dmac4_top_test.sv
`timescale 1ns/1ps
module dmac4_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [3:0] addr_in = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;
    logic [3:0] addr_lo_out, addr_mid_out;
    logic       addr_oe;
    logic [3:0] drq = '0;
    logic [3:0] dack_n;
    logic       hrq;
    logic       hlda = 1'b0;
    logic       memr_n, memw_n, ior_n, iow_n, adstb, tc, mark;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    dmac4_top uut (
        .clk(clk), .rst(rst), .cs(cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .addr_in(addr_in), .din(din), .dout(dout), .dout_en(dout_en),
        .addr_lo_out(addr_lo_out), .addr_mid_out(addr_mid_out), .addr_oe(addr_oe),
        .drq(drq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .adstb(adstb), .tc(tc), .mark(mark)
    );

    // {write, select, write data, expected read data}
    localparam logic [20:0] VEC [20] = '{
        {1'b1, 4'h0, 8'h34, 8'h00}, {1'b1, 4'h0, 8'h12, 8'h00},
        {1'b1, 4'h1, 8'h02, 8'h00}, {1'b1, 4'h1, 8'h80, 8'h00},
        {1'b1, 4'h2, 8'hCD, 8'h00}, {1'b1, 4'h2, 8'hAB, 8'h00},
        {1'b1, 4'h3, 8'h00, 8'h00}, {1'b1, 4'h3, 8'h40, 8'h00},
        {1'b1, 4'h4, 8'h55, 8'h00}, {1'b1, 4'h8, 8'h00, 8'h00},
        {1'b0, 4'h0, 8'h00, 8'h34}, {1'b0, 4'h0, 8'h00, 8'h12},
        {1'b0, 4'h1, 8'h00, 8'h02}, {1'b0, 4'h1, 8'h00, 8'h80},
        {1'b0, 4'h2, 8'h00, 8'hCD}, {1'b0, 4'h2, 8'h00, 8'hAB},
        {1'b0, 4'h3, 8'h00, 8'h00}, {1'b0, 4'h3, 8'h00, 8'h40},
        {1'b0, 4'h4, 8'h00, 8'h55}, {1'b0, 4'h4, 8'h00, 8'h00}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; cpu_wr = 1'b1; addr_in = a; din = d;
        @(posedge clk);
        #1 cs = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; cpu_rd = 1'b1; addr_in = a;
        #1 d = dout;
        @(posedge clk);
        #1 cs = 1'b0; cpu_rd = 1'b0;
    endtask

    // follows nobs transfers of channel ch; transfer index k runs from first
    task automatic do_block(int ch, int nobs, int first, int total, logic [1:0] kind,
                            logic [15:0] base, bit drop, string gtag);
        int seen = 0, k = 0;
        int bad_ack = 0, bad_adr = 0, bad_stb = 0, bad_tc = 0, bad_mark = 0;
        logic [15:0] ea;
        for (int cyc = 0; cyc < 4 * nobs + 40 && seen < nobs; cyc++) begin
            step();
            if (dack_n != 4'hF) begin
                k  = first + seen;
                ea = base + 16'(k);
                if (dack_n !== ~(4'b0001 << ch)) bad_ack++;
                if (addr_lo_out !== ea[3:0] || addr_mid_out !== ea[7:4] || !addr_oe) bad_adr++;
                if (adstb) begin
                    if (dout !== ea[15:8] || !dout_en) bad_adr++;
                end else begin
                    if ({memr_n, memw_n, ior_n, iow_n} !==
                        ~{kind == 2'b10, kind == 2'b01, kind == 2'b01, kind == 2'b10}) bad_stb++;
                    if (tc !== (k + 1 == total)) bad_tc++;
                    if (mark !== ((k + 1) % 128 == 0)) bad_mark++;
                    seen++;
                    if (seen == nobs && drop) drq[ch] = 1'b0;
                end
            end
        end
        check({gtag, " granted channel"}, bad_ack, 0);
        check("R8 transfers seen", seen, nobs);
        check("R6 address outputs", bad_adr, 0);
        check("R7 strobe pairing", bad_stb, 0);
        check("R9 terminal count", bad_tc, 0);
        check("R10 mark timing", bad_mark, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state (R3, R9)
        step();
        check("R3 reset hrq", hrq, 0);
        check("R3 reset acks", dack_n, 4'hF);
        check("R3 reset strobes", {memr_n, memw_n, ior_n, iow_n, adstb}, 5'b11110);
        rd_reg(4'h8, rv);
        check("R9 reset status", rv, 8'h00);

        // register vectors (R1); entries 18 and 19 follow a mode write (R2)
        for (int i = 0; i < 20; i++) begin
            if (VEC[i][20]) wr_reg(VEC[i][19:16], VEC[i][15:8]);
            else begin
                rd_reg(VEC[i][19:16], rv);
                check($sformatf("%s vector %0d", (i >= 18) ? "R2" : "R1", i), rv, VEC[i][7:0]);
            end
        end

        // fixed priority, hold handshake, read and write kinds
        wr_reg(4'h8, 8'h03);
        @(negedge clk);
        drq = 4'b0011; hlda = 1'b0;
        repeat (4) step();
        check("R3 hold raised", hrq, 1);
        check("R3 no ack before grant", dack_n, 4'hF);
        check("R3 no strobe before grant", {memr_n, memw_n, ior_n, iow_n, adstb}, 5'b11110);
        hlda = 1'b1;
        do_block(0, 3, 0, 3, 2'b10, 16'h1234, 1'b0, "R4");
        step();
        check("R9 release after tc", {hrq, dack_n}, {1'b0, 4'hF});
        do_block(1, 1, 0, 1, 2'b01, 16'hABCD, 1'b0, "R4");
        repeat (3) step();
        check("R9 enables cleared", {hrq, dack_n}, {1'b0, 4'hF});
        drq = 4'b0000;
        rd_reg(4'h8, rv);
        check("R9 status set", rv, 8'h03);
        rd_reg(4'h8, rv);
        check("R9 status cleared by read", rv, 8'h00);

        // request dropped in mid block (R11), then resumed (R8)
        wr_reg(4'h8, 8'h00);
        wr_reg(4'h6, 8'h10); wr_reg(4'h6, 8'h00);
        wr_reg(4'h7, 8'h0A); wr_reg(4'h7, 8'h40);
        wr_reg(4'h8, 8'h08);
        @(negedge clk);
        drq = 4'b1000;
        do_block(3, 2, 0, 11, 2'b01, 16'h0010, 1'b1, "R4");
        step();
        check("R11 release on drop", {hrq, dack_n}, {1'b0, 4'hF});
        step();
        check("R11 hold stays low", hrq, 0);
        rd_reg(4'h8, rv);
        check("R11 no status on drop", rv, 8'h00);
        @(negedge clk);
        drq = 4'b1000;
        do_block(3, 1, 2, 11, 2'b01, 16'h0010, 1'b1, "R8");

        // rotating priority (R5)
        wr_reg(4'h8, 8'h00);
        wr_reg(4'h0, 8'h00); wr_reg(4'h0, 8'h01);
        wr_reg(4'h1, 8'h05); wr_reg(4'h1, 8'h40);
        wr_reg(4'h2, 8'h00); wr_reg(4'h2, 8'h02);
        wr_reg(4'h3, 8'h05); wr_reg(4'h3, 8'h80);
        wr_reg(4'h8, 8'h13);
        @(negedge clk);
        drq = 4'b0011;
        do_block(0, 1, 0, 6, 2'b01, 16'h0100, 1'b1, "R5");
        step();
        drq[0] = 1'b1;
        do_block(1, 1, 0, 6, 2'b10, 16'h0200, 1'b1, "R5");
        step();
        drq[1] = 1'b1;
        do_block(0, 1, 1, 6, 2'b01, 16'h0100, 1'b1, "R5");
        step();
        drq = 4'b0000;

        // long verify block: marks at 128 and 256 (R10)
        wr_reg(4'h8, 8'h00);
        wr_reg(4'h4, 8'h00); wr_reg(4'h4, 8'h20);
        wr_reg(4'h5, 8'hFF); wr_reg(4'h5, 8'h00);
        wr_reg(4'h8, 8'h04);
        @(negedge clk);
        drq = 4'b0100;
        do_block(2, 256, 0, 256, 2'b00, 16'h2000, 1'b0, "R4");
        step();
        drq = 4'b0000;
        rd_reg(4'h8, rv);
        check("R9 status after long block", rv, 8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule